// File: doc/BRIEF.md
# Indexed Codec Host Register Port

This block is the byte-wide host register port of an audio codec. The host sees four direct registers through a 2-bit address: an index/control register, a data window onto a bank of 32 indirect registers, a read-only status register, and a playback data register. To reach an indirect register, the host first writes its number into the index field, then reads or writes the data window.

The block guards the data-format and interface-configuration indirect registers behind a mode-change flag. The only exception is the two stream-enable bits. The block also locks out the index and data window while the codec is busy initializing or is placed in software power-down. It holds back DMA requests while an interrupt is pending, if the host asks for that, and it drives the IRQ pin only when the interrupt enable bit is set. The bank is a plain byte array. The block interprets only the enable bits, the interrupt enable and the power-management field.

Read data is registered. A read strobe in one cycle presents the addressed register's value on `rdata` from the next cycle on, and that value reflects the state before any write made in the same cycle.

Top module: `codec_host_regs`

## Requirements
- R1: Direct register 0 reads as {busy(bit7), MCE(bit6), TRD(bit5), index(bits4..0)}. After reset, with no lockout, it reads 0x40.
- R2: Direct register 1 reads and writes the indirect register whose number is held in the index field.
- R3: With `ext_mode` low, index bit 4 is stored as 0 on every write to register 0, so only indirect registers 0..15 are reachable. With `ext_mode` high, index bit 4 is stored as written.
- R4: While `init_busy` is high, or while bits 1..0 of indirect register 11 equal 01, writes to registers 0 and 1 are ignored and both read 0x80.
- R5: While MCE is 0, writes to indirect register 8 change nothing. Writes to indirect register 9 change only its bits 1..0.
- R6: `dac_mute` is high exactly while MCE is 1.
- R7: With TRD at 0, each DMA request output equals its input. With TRD at 1, each request passes only while INT is 0.
- R8: Register 2 reads {6'b0, PRDY(bit1), INT(bit0)}. Any write to register 2 clears INT, and `irq_event` sets INT. If both happen in the same cycle, the set wins.
- R9: `irq_out` equals INT AND bit 1 (IEN) of indirect register 10.
- R10: PRDY resets to 1. A write to register 3 clears PRDY, and `sample_taken` sets it. If both happen in the same cycle, the write wins and PRDY ends at 0. Register 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Direct register select |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| init_busy | input | 1 | Codec is initializing |
| ext_mode | input | 1 | 1 = extended (32 indirect), 0 = legacy (16) |
| irq_event | input | 1 | One-cycle interrupt source |
| sample_taken | input | 1 | Playback byte consumed |
| play_drq_in | input | 1 | Raw playback DMA request |
| cap_drq_in | input | 1 | Raw capture DMA request |
| play_drq_out | output | 1 | Gated playback DMA request |
| cap_drq_out | output | 1 | Gated capture DMA request |
| irq_out | output | 1 | Interrupt pin |
| dac_mute | output | 1 | DAC mute while mode change is open |

## Verification
Two pairs of functions can fall in the same cycle. An interrupt event can coincide with the host's clearing write to the status register, and a playback-data write can coincide with a sample-consumed pulse. The bench drives both members of each pair in one cycle. It then judges the resulting INT and PRDY through the status register, and through the IRQ and DMA outputs, against a behavioural model that applies the priorities stated in R8 and R10. The model is stepped on every clock.

// File: rtl/codec_host_pkg.sv
package codec_host_pkg;
  localparam int DW            = 8;
  localparam int FMT_IDX       = 8;
  localparam int CFG_IDX       = 9;
  localparam int PIN_IDX       = 10;
  localparam int PWR_IDX       = 11;
  localparam int IEN_BIT       = 1;
  localparam logic [7:0] CFG_LIVE_MASK = 8'h03;
  localparam logic [1:0] PM_DOWN       = 2'b01;
  localparam logic [7:0] LOCK_READ     = 8'h80;

  typedef enum logic [1:0] {
    A_INDEX  = 2'd0,
    A_DATA   = 2'd1,
    A_STATUS = 2'd2,
    A_PLAY   = 2'd3
  } dreg_e;

  // lockout when busy or in software power-down
  function automatic logic lockout(input logic busy, input logic [1:0] pm);
    return busy || (pm == PM_DOWN);
  endfunction

  // bits of an indirect register a host write may change
  function automatic logic [7:0] ind_wmask(input int unsigned idx, input logic mce);
    if (mce) return 8'hFF;
    if (idx == FMT_IDX) return 8'h00;
    if (idx == CFG_IDX) return CFG_LIVE_MASK;
    return 8'hFF;
  endfunction

  function automatic logic drq_gate(input logic req, input logic trd, input logic intf);
    return req && !(trd && intf);
  endfunction
endpackage

// File: rtl/codec_idx_ctrl.sv
module codec_idx_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_idx,
  input  logic [6:0]       wdata,
  input  logic             ext_mode,
  input  logic             locked,
  output logic             mce,
  output logic             trd,
  output logic [IDX_W-1:0] ia
);
  logic idx_take;
  assign idx_take = wr_idx && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mce <= 1'b1;
      trd <= 1'b0;
      ia  <= '0;
    end else if (idx_take) begin
      mce <= wdata[6];
      trd <= wdata[5];
      ia  <= {wdata[IDX_W-1] & ext_mode, wdata[IDX_W-2:0]};
    end
  end

  AST_LOCK_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx && locked) |=> $stable({mce, trd, ia})); // R4
  AST_LEGACY_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx && !ext_mode) |=> !ia[IDX_W-1]); // R3
endmodule

// File: rtl/codec_ind_file.sv
module codec_ind_file
  import codec_host_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data,
  input  logic [IDX_W-1:0] idx,
  input  logic             mce,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_val,
  output logic             ien,
  output logic [1:0]       pm
);
  localparam int N_IND = 1 << IDX_W;

  logic [7:0] bank [N_IND];

  generate
    for (genvar g = 0; g < N_IND; g++) begin : g_reg
      logic [7:0] msk;
      assign msk = ind_wmask(g, mce);
      always_ff @(posedge clk) begin
        if (!rst_n)
          bank[g] <= '0;
        else if (wr_data && (idx == IDX_W'(g)))
          bank[g] <= (bank[g] & ~msk) | (wdata & msk);
      end
    end
  endgenerate

  assign rd_val = bank[idx];
  assign ien    = bank[PIN_IDX][IEN_BIT];
  assign pm     = bank[PWR_IDX][1:0];

  AST_FMT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !mce && idx == IDX_W'(FMT_IDX)) |=> $stable(bank[FMT_IDX])); // R5
  AST_CFG_UPPER_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !mce && idx == IDX_W'(CFG_IDX)) |=> $stable(bank[CFG_IDX][7:2])); // R5
endmodule

// File: rtl/codec_status.sv
module codec_status (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_event,
  input  logic wr_stat,
  input  logic wr_play,
  input  logic sample_taken,
  output logic int_f,
  output logic prdy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_f <= 1'b0;
      prdy  <= 1'b1;
    end else begin
      if (irq_event)    int_f <= 1'b1;
      else if (wr_stat) int_f <= 1'b0;
      if (wr_play)           prdy <= 1'b0;
      else if (sample_taken) prdy <= 1'b1;
    end
  end

  AST_INT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> int_f); // R8
  AST_INT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !irq_event) |=> !int_f); // R8
  AST_PRDY_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_play |=> !prdy); // R10
endmodule

// File: rtl/codec_host_regs.sv
module codec_host_regs
  import codec_host_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       init_busy,
  input  logic       ext_mode,
  input  logic       irq_event,
  input  logic       sample_taken,
  input  logic       play_drq_in,
  input  logic       cap_drq_in,
  output logic       play_drq_out,
  output logic       cap_drq_out,
  output logic       irq_out,
  output logic       dac_mute
);
  logic             wr_idx, wr_data, wr_stat, wr_play, locked;
  logic             mce, trd, int_f, prdy, ien;
  logic [IDX_W-1:0] ia;
  logic [1:0]       pm;
  logic [7:0]       ind_val, rd_next;

  assign locked  = lockout(init_busy, pm);
  assign wr_idx  = wr_en && (addr == A_INDEX);
  assign wr_data = wr_en && (addr == A_DATA) && !locked;
  assign wr_stat = wr_en && (addr == A_STATUS);
  assign wr_play = wr_en && (addr == A_PLAY);

  codec_idx_ctrl #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx), .wdata(wdata[6:0]),
    .ext_mode(ext_mode), .locked(locked), .mce(mce), .trd(trd), .ia(ia)
  );

  codec_ind_file #(.IDX_W(IDX_W)) u_ind (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .idx(ia), .mce(mce),
    .wdata(wdata), .rd_val(ind_val), .ien(ien), .pm(pm)
  );

  codec_status u_stat (
    .clk(clk), .rst_n(rst_n), .irq_event(irq_event), .wr_stat(wr_stat),
    .wr_play(wr_play), .sample_taken(sample_taken), .int_f(int_f), .prdy(prdy)
  );

  always_comb begin
    unique case (dreg_e'(addr))
      A_INDEX:  rd_next = locked ? LOCK_READ : {1'b0, mce, trd, 5'(ia)};
      A_DATA:   rd_next = locked ? LOCK_READ : ind_val;
      A_STATUS: rd_next = {6'b0, prdy, int_f};
      default:  rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign play_drq_out = drq_gate(play_drq_in, trd, int_f);
  assign cap_drq_out  = drq_gate(cap_drq_in, trd, int_f);
  assign irq_out      = int_f && ien;
  assign dac_mute     = mce;

  AST_DRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trd && int_f) |-> !(play_drq_out || cap_drq_out)); // R7
  AST_DRQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !trd |-> (play_drq_out == play_drq_in && cap_drq_out == cap_drq_in)); // R7
  AST_IRQ_NEEDS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> int_f); // R9
  AST_LOCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && locked && addr == 2'd1) |=> rdata == 8'h80); // R4
endmodule

// File: tb/sim_codec_host_regs.sv
module sim_codec_host_regs;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0, init_busy = 1, ext_mode = 1;
  logic irq_event = 0, sample_taken = 0, play_drq_in = 0, cap_drq_in = 0;
  logic [7:0] wdata = 0, rdata;
  logic play_drq_out, cap_drq_out, irq_out, dac_mute;

  always #10 clk = ~clk;

  codec_host_regs u0 (.*);

  int total = 0, bad = 0;
  string rd_tag = "R1";

  // behavioural reference model
  bit m_mce, m_trd, m_int, m_prdy;
  int m_ia;
  byte unsigned m_bank [32];
  byte unsigned m_rd;

  function automatic bit m_locked();
    return init_busy || ((m_bank[11] & 3) == 1);
  endfunction

  function automatic byte unsigned m_read(int a);
    if (a == 0) return m_locked() ? 8'h80 : byte'((m_mce << 6) | (m_trd << 5) | m_ia);
    if (a == 1) return m_locked() ? 8'h80 : m_bank[m_ia];
    if (a == 2) return byte'((m_prdy << 1) | m_int);
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mce = 1; m_trd = 0; m_ia = 0; m_int = 0; m_prdy = 1; m_rd = 0;
      foreach (m_bank[i]) m_bank[i] = 0;
    end else begin
      bit lk;
      lk = m_locked();
      if (rd_en) m_rd = m_read(addr);
      if (wr_en && addr == 0 && !lk) begin
        m_mce = wdata[6]; m_trd = wdata[5];
        m_ia = (ext_mode ? wdata[4] * 16 : 0) + wdata[3:0];
      end else if (wr_en && addr == 1 && !lk) begin
        if (m_mce || (m_ia != 8 && m_ia != 9)) m_bank[m_ia] = wdata;
        else if (m_ia == 9) m_bank[9] = (m_bank[9] & 8'hFC) | (wdata & 8'h03);
      end
      if (irq_event) m_int = 1;
      else if (wr_en && addr == 2) m_int = 0;
      if (wr_en && addr == 3) m_prdy = 0;
      else if (sample_taken) m_prdy = 1;
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(rd_tag, "rdata", rdata, m_rd);
    chk("R7", "play_drq", play_drq_out, play_drq_in && !(m_trd && m_int));
    chk("R7", "cap_drq", cap_drq_out, cap_drq_in && !(m_trd && m_int));
    chk("R9", "irq", irq_out, m_int && m_bank[10][1]);
    chk("R6", "mute", dac_mute, m_mce);
  end

  task automatic idle();
    @(posedge clk); #2;
    wr_en = 0; rd_en = 0; irq_event = 0; sample_taken = 0;
  endtask
  task automatic wr(int a, int d);
    @(posedge clk); #2;
    rd_en = 0; irq_event = 0; sample_taken = 0;
    wr_en = 1; addr = 2'(a); wdata = 8'(d);
  endtask
  task automatic rd(int a, string tag, int exp);
    @(posedge clk); #2;
    wr_en = 0; irq_event = 0; sample_taken = 0;
    rd_en = 1; addr = 2'(a); rd_tag = tag;
    @(posedge clk); #2; rd_en = 0;
    @(negedge clk); chk(tag, "directed read", rdata, exp);
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    rd(0, "R4", 8'h80);
    wr(0, 8'h05);
    rd(1, "R4", 8'h80);
    idle(); init_busy = 0;
    rd(0, "R1", 8'h40);                 // reset value, index write above ignored
    // IEN on, then interrupt
    wr(0, 8'h0A); wr(1, 8'h02);
    rd(1, "R2", 8'h02);
    wr(2, 0); irq_event = 1;            // clear and set same cycle
    idle();
    rd(2, "R8", 8'h03);
    idle(); play_drq_in = 1; cap_drq_in = 1;
    wr(0, 8'h2A);                       // TRD on
    idle(); idle();
    wr(2, 8'hFF);                       // clear INT, requests resume
    idle();
    rd(2, "R8", 8'h02);
    irq_event = 1; idle(); idle();
    wr(0, 8'h0A); idle();               // TRD off, requests pass with INT set
    wr(2, 0); idle(); play_drq_in = 0;
    // mode-change protection
    wr(0, 8'h08); wr(1, 8'hFF);
    rd(1, "R5", 8'h00);
    wr(0, 8'h09); wr(1, 8'hFF);
    rd(1, "R5", 8'h03);
    wr(0, 8'h49); wr(1, 8'hA4);
    rd(1, "R5", 8'hA4);
    wr(0, 8'h48); wr(1, 8'h5A);
    rd(1, "R2", 8'h5A);
    // legacy vs extended index
    ext_mode = 0; wr(0, 8'h1F);
    rd(0, "R3", 8'h0F);
    wr(1, 8'h33);
    ext_mode = 1; wr(0, 8'h1F); wr(1, 8'h77);
    rd(1, "R3", 8'h77);
    wr(0, 8'h0F);
    rd(1, "R3", 8'h33);
    // playback data ready
    rd(3, "R10", 8'h00);
    rd(2, "R10", 8'h02);
    wr(3, 8'h11); idle();
    rd(2, "R10", 8'h00);
    sample_taken = 1; idle();
    rd(2, "R10", 8'h02);
    wr(3, 8'h22); sample_taken = 1; idle();
    rd(2, "R10", 8'h00);
    // software power-down lockout
    wr(0, 8'h0B); wr(1, 8'h01); idle();
    rd(0, "R4", 8'h80);
    wr(0, 8'h48); wr(1, 8'hEE);
    rd(1, "R4", 8'h80);
    repeat (3) idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule